// File: doc/BRIEF.md
# Unsigned Multiply/Divide Sequencer

This block computes unsigned products and quotients over a pair of implicit accumulator halves, one bit per clock. A caller presents the low accumulator word, the high accumulator word, an explicit source operand, an operation select and a width select together with a one-cycle start strobe. The block captures all of them, spends one cycle preparing its datapath, then runs a shift-add multiply or a restoring divide for 8 or 16 iterations. It ends with a one-cycle done strobe and the updated accumulator halves and flags.

The results go back into fixed places that depend on the width. A byte multiply takes the low byte of the low word and writes the 16-bit product over the whole low word. A word multiply splits its 32-bit product across the high word and the low word. A byte divide divides the whole low word and packs the remainder above the quotient. A word divide divides the 32-bit high:low pair and writes the quotient to the low word and the remainder to the high word. A zero divisor, or a quotient wider than the destination, is reported on an error pin and is not trapped.

Input rules: the start strobe is taken only while `busy` is low. `busy` low is the ready condition, and a strobe given while `busy` is high is dropped. The output side has no back-pressure: results are valid in the cycle `done` is high and stay on the pins until the next `done`.

Top module: `umd_unit`

## Requirements
- R1: A byte multiply (`op_div`=0, `wide`=0) returns `ax_in[7:0]` times `src_in[7:0]` as a 16-bit value on `ax_out`. `dx_out` repeats the captured `dx_in`.
- R2: A word multiply (`op_div`=0, `wide`=1) returns the 32-bit product of `ax_in` and `src_in`. The upper 16 bits go to `dx_out` and the lower 16 bits to `ax_out`.
- R3: After a multiply, `cf_out` and `of_out` are both 1 when the upper half of the product is nonzero, and both 0 otherwise. That upper half is `ax_out[15:8]` for a byte multiply and `dx_out` for a word multiply. After any divide both flags are 0, so the two flags always agree.
- R4: A byte divide (`op_div`=1, `wide`=0) divides `ax_in` by `src_in[7:0]`. The quotient goes to `ax_out[7:0]`, the remainder to `ax_out[15:8]`, and `dx_out` repeats `dx_in`.
- R5: A word divide (`op_div`=1, `wide`=1) divides the 32-bit value {`dx_in`,`ax_in`} by `src_in`. The quotient goes to `ax_out` and the remainder to `dx_out`.
- R6: A divide with a zero divisor, or whose quotient exceeds 255 (byte) or 65535 (word), completes with `err_out`=1. In that case `ax_out` and `dx_out` repeat the captured `ax_in` and `dx_in`, and both flags are 0. Every other completion has `err_out`=0.
- R7: Counting from the clock edge that accepts start, `done` is high after edge 9 for a byte operation and after edge 17 for a word operation. For an erroring divide, `done` is high after edge 1.
- R8: `busy` rises only on an edge that accepts start. It stays high until the done cycle, in which it is low. A start given while `busy` is high has no effect on the running result and does not cause another run.
- R9: `done` lasts one cycle. `ax_out`, `dx_out`, `err_out`, `cf_out` and `of_out` change only in a done cycle.
- R10: During reset and after it, until the first operation, `busy`, `done`, `err_out`, `cf_out`, `of_out`, `ax_out` and `dx_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; taken only while busy is low |
| op_div | input | 1 | 0 multiply, 1 divide |
| wide | input | 1 | 0 byte operation, 1 word operation |
| ax_in | input | 16 | Low accumulator word |
| dx_in | input | 16 | High accumulator word |
| src_in | input | 16 | Explicit source operand (low byte used for byte width) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| ax_out | output | 16 | Updated low accumulator word |
| dx_out | output | 16 | Updated high accumulator word |
| cf_out | output | 1 | Carry flag: upper half of product nonzero |
| of_out | output | 1 | Overflow flag, equal to cf_out |
| err_out | output | 1 | Divide error: zero divisor or quotient too wide |

## Verification
Each completion is due at a fixed distance from the accepting edge: 9 edges for byte work, 17 for word work, and 1 for a divide that errors. The bench counts rising edges from the accepting edge, samples at the falling edge after each one, and requires `done` to appear at exactly the expected count. Results and flags are read in that same done cycle. One falling edge later the bench confirms that the outputs held and that `busy` stayed low, which also covers the start strobe it injects mid-run.

// File: rtl/umd_pkg.sv
package umd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } umd_state_e;
endpackage

// File: rtl/umd_ctrl.sv
module umd_ctrl
  import umd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wide,
  input  logic fault,
  output logic busy,
  output logic accept,
  output logic setup,
  output logic step,
  output logic last
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  umd_state_e       state;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_SETUP;
        ST_SETUP: begin
          if (fault) begin
            state <= ST_IDLE;
          end else begin
            state  <= ST_RUN;
            remain <= wide ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
          end
        end
        ST_RUN: begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && start;
  assign setup  = (state == ST_SETUP);
  assign step   = (state == ST_RUN);
  assign last   = step && (remain == CNT_W'(1));
endmodule

// File: rtl/umd_mul_step.sv
module umd_mul_step #(
  parameter int WORD_W = 16
) (
  input  logic [2*WORD_W-1:0] acc_i,
  input  logic                add_i,
  input  logic [WORD_W-1:0]   mcand_i,
  output logic [2*WORD_W-1:0] acc_o
);
  localparam int ACC_W = 2 * WORD_W;

  logic [ACC_W-1:0] addend;

  // MSB-first shift-add: double the partial product, then add the multiplicand
  assign addend = add_i ? {{WORD_W{1'b0}}, mcand_i} : '0;
  assign acc_o  = {acc_i[ACC_W-2:0], 1'b0} + addend;
endmodule

// File: rtl/umd_div_step.sv
module umd_div_step #(
  parameter int WORD_W = 16
) (
  input  logic [2*WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0]   dvsr_i,
  output logic [2*WORD_W-1:0] acc_o
);
  localparam int ACC_W = 2 * WORD_W;

  logic [WORD_W:0] trial;
  logic [WORD_W:0] diff;
  logic            fits;

  // Upper half: partial remainder; lower half: dividend bits shifting out, quotient bits shifting in
  assign trial = {acc_i[ACC_W-1:WORD_W], acc_i[WORD_W-1]};
  assign diff  = trial - {1'b0, dvsr_i};
  assign fits  = (trial >= {1'b0, dvsr_i});
  assign acc_o = {(fits ? diff[WORD_W-1:0] : trial[WORD_W-1:0]),
                  acc_i[WORD_W-2:0], fits};
endmodule

// File: rtl/umd_unit.sv
module umd_unit
  import umd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_div,
  input  logic              wide,
  input  logic [WORD_W-1:0] ax_in,
  input  logic [WORD_W-1:0] dx_in,
  input  logic [WORD_W-1:0] src_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] ax_out,
  output logic [WORD_W-1:0] dx_out,
  output logic              cf_out,
  output logic              of_out,
  output logic              err_out
);
  localparam int HALF_W = WORD_W / 2;
  localparam int ACC_W  = 2 * WORD_W;

  logic              accept, setup, step, last, fault;
  logic              div_q, wide_q;
  logic [WORD_W-1:0] ax_q, dx_q, src_q;
  logic [ACC_W-1:0]  acc, acc_mul, acc_div, acc_nx;
  logic [WORD_W-1:0] mq;
  logic [WORD_W-1:0] lo_init, opnd, div_hi;
  logic [WORD_W-1:0] hi_nx, lo_nx, res_ax, res_dx;
  logic              res_flag;

  umd_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wide   (wide_q),
    .fault  (fault),
    .busy   (busy),
    .accept (accept),
    .setup  (setup),
    .step   (step),
    .last   (last)
  );

  // Operand alignment: a byte operand sits in the top of the shifting half
  assign lo_init = wide_q ? ax_q : {ax_q[HALF_W-1:0], {HALF_W{1'b0}}};
  assign opnd    = wide_q ? src_q : {{HALF_W{1'b0}}, src_q[HALF_W-1:0]};
  assign div_hi  = wide_q ? dx_q : {{HALF_W{1'b0}}, ax_q[WORD_W-1:HALF_W]};
  // Quotient fits only when the upper dividend half is below the divisor (covers zero)
  assign fault   = div_q && (div_hi >= opnd);

  umd_mul_step #(.WORD_W(WORD_W)) i_mul (
    .acc_i   (acc),
    .add_i   (mq[WORD_W-1]),
    .mcand_i (opnd),
    .acc_o   (acc_mul)
  );

  umd_div_step #(.WORD_W(WORD_W)) i_div (
    .acc_i  (acc),
    .dvsr_i (opnd),
    .acc_o  (acc_div)
  );

  assign acc_nx = div_q ? acc_div : acc_mul;
  assign hi_nx  = acc_nx[ACC_W-1:WORD_W];
  assign lo_nx  = acc_nx[WORD_W-1:0];

  always_comb begin
    if (div_q) begin
      res_ax   = wide_q ? lo_nx : {hi_nx[HALF_W-1:0], lo_nx[HALF_W-1:0]};
      res_dx   = wide_q ? hi_nx : dx_q;
      res_flag = 1'b0;
    end else begin
      res_ax   = lo_nx;
      res_dx   = wide_q ? hi_nx : dx_q;
      res_flag = wide_q ? (|hi_nx) : (|lo_nx[WORD_W-1:HALF_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      wide_q <= 1'b0;
      ax_q   <= '0;
      dx_q   <= '0;
      src_q  <= '0;
      acc    <= '0;
      mq     <= '0;
    end else begin
      if (accept) begin
        div_q  <= op_div;
        wide_q <= wide;
        ax_q   <= ax_in;
        dx_q   <= dx_in;
        src_q  <= src_in;
      end
      if (setup) begin
        acc <= div_q ? {div_hi, lo_init} : '0;
        mq  <= lo_init;
      end else if (step) begin
        acc <= acc_nx;
        mq  <= {mq[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      ax_out  <= '0;
      dx_out  <= '0;
      cf_out  <= 1'b0;
      of_out  <= 1'b0;
      err_out <= 1'b0;
    end else begin
      done <= 1'b0;
      if (setup && fault) begin
        done    <= 1'b1;
        ax_out  <= ax_q;
        dx_out  <= dx_q;
        cf_out  <= 1'b0;
        of_out  <= 1'b0;
        err_out <= 1'b1;
      end else if (last) begin
        done    <= 1'b1;
        ax_out  <= res_ax;
        dx_out  <= res_dx;
        cf_out  <= res_flag;
        of_out  <= res_flag;
        err_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/umd_unit_chk.sv
module umd_unit_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err_out,
  input logic              cf_out,
  input logic              of_out,
  input logic [WORD_W-1:0] ax_out,
  input logic [WORD_W-1:0] dx_out
);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r3_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
    cf_out == of_out);

  a_r6_err_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_out) |-> (!cf_out && !of_out));

  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ax_out) && $stable(dx_out) && $stable(err_out)));
endmodule

bind umd_unit umd_unit_chk #(.WORD_W(WORD_W)) i_umd_unit_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err_out (err_out),
  .cf_out  (cf_out),
  .of_out  (of_out),
  .ax_out  (ax_out),
  .dx_out  (dx_out)
);

// File: tb/test_umd_unit.sv
`timescale 1ns/1ps
module test_umd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] ax_in = '0, dx_in = '0, src_in = '0;
  logic        busy, done, cf_out, of_out, err_out;
  logic [15:0] ax_out, dx_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  umd_unit i_umd_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div), .wide(wide),
    .ax_in(ax_in), .dx_in(dx_in), .src_in(src_in),
    .busy(busy), .done(done), .ax_out(ax_out), .dx_out(dx_out),
    .cf_out(cf_out), .of_out(of_out), .err_out(err_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit dv, input bit wd,
                                input logic [15:0] a, input logic [15:0] d,
                                input logic [15:0] s,
                                output logic [15:0] ea, output logic [15:0] ed,
                                output bit ef, output bit ee);
    logic [31:0] p, dd, dvsr, qq, rr;
    ea = a; ed = d; ef = 1'b0; ee = 1'b0;
    if (!dv) begin
      if (!wd) begin
        p  = {24'd0, a[7:0]} * {24'd0, s[7:0]};
        ea = p[15:0];
        ef = (p[15:8] != 8'd0);
      end else begin
        p  = {16'd0, a} * {16'd0, s};
        ea = p[15:0];
        ed = p[31:16];
        ef = (p[31:16] != 16'd0);
      end
    end else begin
      dd   = wd ? {d, a} : {16'd0, a};
      dvsr = wd ? {16'd0, s} : {24'd0, s[7:0]};
      if (dvsr == 32'd0) ee = 1'b1;
      else begin
        qq = dd / dvsr;
        rr = dd % dvsr;
        if (qq > (wd ? 32'd65535 : 32'd255)) ee = 1'b1;
        else if (wd) begin
          ea = qq[15:0];
          ed = rr[15:0];
        end else ea = {rr[7:0], qq[7:0]};
      end
    end
  endfunction

  task automatic run_op(input bit dv, input bit wd, input logic [15:0] a,
                        input logic [15:0] d, input logic [15:0] s, input bit inject);
    logic [15:0] ea, ed, hold_ax;
    bit ef, ee, seen;
    int n, exp_n;
    string req;
    model(dv, wd, a, d, s, ea, ed, ef, ee);
    exp_n = ee ? 1 : (wd ? 17 : 9);
    req = ee ? "R6" : (dv ? (wd ? "R5" : "R4") : (wd ? "R2" : "R1"));
    @(negedge clk);
    start = 1'b1; op_div = dv; wide = wd; ax_in = a; dx_in = d; src_in = s;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0; seen = 1'b0;
    while (!seen && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) seen = 1'b1;
      if (n == 3 && inject && !ee) begin
        start = 1'b1; op_div = ~dv; wide = ~wd;
        ax_in = $urandom; dx_in = $urandom; src_in = $urandom;
      end else start = 1'b0;
    end
    chk(seen && n == exp_n, "R7", "done latency", n, exp_n);
    chk(err_out == ee, "R6", "error flag", {31'd0, err_out}, {31'd0, ee});
    chk(ax_out == ea, req, "ax result", {16'd0, ax_out}, {16'd0, ea});
    chk(dx_out == ed, req, "dx result", {16'd0, dx_out}, {16'd0, ed});
    chk(cf_out == ef && of_out == ef, "R3", "cf/of",
        {30'd0, cf_out, of_out}, {30'd0, ef, ef});
    chk(!busy, "R8", "busy low in done cycle", {31'd0, busy}, 32'd0);
    hold_ax = ax_out;
    @(negedge clk);
    chk(!done && !busy, "R8", "no extra run after ignored start",
        {30'd0, done, busy}, 32'd0);
    chk(ax_out == hold_ax, "R9", "ax held after done", {16'd0, ax_out}, {16'd0, hold_ax});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual no completion expected run to finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] a, d, s;
    bit dv, wd;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !err_out && !cf_out && !of_out && ax_out == 0 && dx_out == 0,
        "R10", "reset state", {16'd0, ax_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && ax_out == 0, "R10", "state after reset", {31'd0, busy}, 32'd0);

    run_op(1'b0, 1'b0, 16'h12FD, 16'hBEEF, 16'h0005, 1'b1); // R1 R3: FD*05 = 04F1, flags set
    run_op(1'b0, 1'b0, 16'h0010, 16'h1111, 16'h0002, 1'b0); // R1 R3: flags clear
    run_op(1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b1); // R2 max operands
    run_op(1'b0, 1'b1, 16'h0123, 16'hAAAA, 16'h0010, 1'b0); // R2 R3 upper zero
    run_op(1'b1, 1'b0, 16'h00C8, 16'h7777, 16'h0006, 1'b1); // R4
    run_op(1'b1, 1'b0, 16'h0FFF, 16'h0000, 16'h0010, 1'b0); // R4 quotient exactly FF
    run_op(1'b1, 1'b0, 16'h1000, 16'h2222, 16'h0010, 1'b0); // R6 byte quotient overflow
    run_op(1'b1, 1'b0, 16'h1234, 16'h5678, 16'hFF00, 1'b0); // R6 byte divisor zero
    run_op(1'b1, 1'b1, 16'hFFFF, 16'h0003, 16'h0004, 1'b1); // R5 quotient exactly FFFF
    run_op(1'b1, 1'b1, 16'h0000, 16'h0004, 16'h0004, 1'b0); // R6 word quotient overflow
    run_op(1'b1, 1'b1, 16'h9999, 16'h0001, 16'h0000, 1'b0); // R6 word divisor zero

    for (int i = 0; i < 300; i++) begin
      dv = $urandom_range(0, 1);
      wd = $urandom_range(0, 1);
      a = $urandom; d = $urandom; s = $urandom;
      if (dv && ($urandom_range(0, 3) != 0)) begin
        if (wd) d = (s == 0) ? 16'd0 : d % s;
        else a[15:8] = (s[7:0] == 0) ? 8'd0 : a[15:8] % s[7:0];
      end
      run_op(dv, wd, a, d, s, ($urandom_range(0, 2) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule